// File: doc/BRIEF.md
# Transmit Request Pending Manager

This block keeps the request state for a bank of transmit buffers in a CAN-style controller. Software asks for buffers to be sent by writing a set-request word, and withdraws requests by writing a cancel word. Each word has one bit per buffer, and a 1 bit acts on its buffer. From the pending buffers that are not being cancelled, the block offers the buffer with the lowest message ID to the transmit engine. It then tracks that frame until the engine reports how it ended. Four bit vectors can be read at any time: pending, cancel-requested, transmission-occurred and cancellation-finished.

The offer to the engine is a valid/ready stream. `tx_valid` is high while a candidate exists and no frame is in flight. The engine takes the buffer in `tx_idx` on the cycle when `tx_valid` and `tx_ready` are both high. While the offer waits for `tx_ready`, `tx_idx` may move to a better candidate. The index that counts is the one presented in the accepting cycle. After acceptance no new offer is made until the engine pulses `done_valid` with a status. A cancel for a buffer already on the bus waits until that frame ends. A mode input stops failed frames from being retried.

Top module: `txq_pending_mgr`

## Requirements
- R1: After reset, all four bit vectors are zero and `tx_valid` is low.
- R2: A set-request write with bit i at 1 sets pending bit i on the next clock edge, but only when i is below `cfg_nbuf`. The same write clears transmission-occurred bit i and cancellation-finished bit i. Zero bits and buffers out of range have no effect.
- R3: When a set request and a cancel request for the same buffer arrive in the same cycle, the set request is ignored.
- R4: The offered buffer is the one with the lowest message ID among buffers that are pending and have no cancel request. On equal IDs the lower index wins. `tx_valid` is low when there is no such buffer.
- R5: Acceptance (`tx_valid` and `tx_ready` both high) starts a frame. `tx_valid` then stays low, and the buffer in flight stays fixed until `done_valid`. Before acceptance the offered index follows the best candidate.
- R6: Status 2'b00 means success. On success, one cycle after `done_valid` the buffer's pending bit is 0 and its transmission-occurred bit is 1.
- R7: Status 2'b01 means lost arbitration, and 2'b10 or 2'b11 means a bus error. On either failure, in normal mode with no cancel request, the buffer stays pending and is offered again.
- R8: A cancel write to a pending buffer that is not in flight sets the cancel-request bit on the next edge. On the edge after that, pending is cleared and cancellation-finished is set.
- R9: A cancel of the buffer in flight keeps pending set until `done_valid`, and then clears it and sets cancellation-finished. If the frame succeeded, transmission-occurred is also set.
- R10: A cancel-request bit clears on the edge after its pending bit is seen clear. A cancel write to a buffer that is not pending is ignored.
- R11: With `no_retx` high, a failed frame clears pending and sets cancellation-finished, without a cancel request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_nbuf | input | 6 | Number of buffers configured for transmit |
| no_retx | input | 1 | Automatic retransmission disabled |
| add_we | input | 1 | Set-request write strobe |
| add_data | input | 32 | Set-request word, 1 per buffer to request |
| cxl_we | input | 1 | Cancel write strobe |
| cxl_data | input | 32 | Cancel word, 1 per buffer to cancel |
| msg_ids | input | 352 | Message ID per buffer, 11 bits each, buffer i at [11i+10:11i] |
| tx_valid | output | 1 | A buffer is offered to the engine |
| tx_ready | input | 1 | Engine accepts the offered buffer |
| tx_idx | output | 5 | Index of the offered buffer |
| done_valid | input | 1 | Frame in flight has ended |
| done_status | input | 2 | Outcome: 00 ok, 01 arbitration lost, 1x error |
| pend | output | 32 | Pending bits |
| cxl_req | output | 32 | Cancel-request bits |
| tx_occ | output | 32 | Transmission-occurred bits |
| cxl_fin | output | 32 | Cancellation-finished bits |

## Verification
Some rules are checked on every cycle by the assertions. A buffer never becomes pending outside the configured range. The offered buffer is always pending and not being cancelled. The frame in flight holds its index until its end report. A cancelled buffer in flight stays pending until its frame ends. A cancel-request bit never outlives its pending bit by more than one edge. Other behaviour depends on a sequence of events, and only the bench's scenarios show it. This covers lowest-ID and tie-break selection, the offer switching before acceptance, and retry after a failure. It also covers cancel winning over a set request, and the cancellation outcomes for idle, in-flight successful, in-flight failed and no-retransmit frames.

// File: rtl/txq_pkg.sv
package txq_pkg;
  typedef enum logic [1:0] {
    TXS_OK  = 2'b00,
    TXS_ARB = 2'b01,
    TXS_ERR = 2'b10,
    TXS_ER2 = 2'b11
  } txq_status_e;
endpackage

// File: rtl/txq_prio_scan.sv
module txq_prio_scan #(
  parameter int NBUF = 32,
  parameter int IDW  = 11,
  localparam int IW  = $clog2(NBUF)
) (
  input  logic [NBUF-1:0]     cand,
  input  logic [NBUF*IDW-1:0] ids,
  output logic                any,
  output logic [IW-1:0]       idx
);
  logic [IDW-1:0] best;

  // Linear minimum search: strict less-than keeps the lower index on ties.
  always_comb begin
    any  = 1'b0;
    idx  = '0;
    best = '1;
    for (int i = 0; i < NBUF; i++) begin
      if (cand[i] && (!any || ids[i*IDW +: IDW] < best)) begin
        any  = 1'b1;
        idx  = IW'(i);
        best = ids[i*IDW +: IDW];
      end
    end
  end
endmodule

// File: rtl/txq_slot.sv
module txq_slot (
  input  logic clk,
  input  logic rst_n,
  input  logic add_set,
  input  logic cxl_set,
  input  logic is_active,
  input  logic tx_end,
  input  logic tx_ok,
  input  logic no_retx,
  output logic pend_q,
  output logic creq_q,
  output logic occ_q,
  output logic fin_q
);
  logic pend_d, creq_d, occ_d, fin_d;

  always_comb begin
    pend_d = pend_q;
    creq_d = creq_q;
    occ_d  = occ_q;
    fin_d  = fin_q;
    if (tx_end) begin
      if (tx_ok) begin
        pend_d = 1'b0;
        occ_d  = 1'b1;
        if (creq_q) fin_d = 1'b1;
      end else if (creq_q || no_retx) begin
        pend_d = 1'b0;
        fin_d  = 1'b1;
      end
    end else if (creq_q && pend_q && !is_active) begin
      pend_d = 1'b0;
      fin_d  = 1'b1;
    end
    if (!pend_q)      creq_d = 1'b0;
    else if (cxl_set) creq_d = 1'b1;
    if (add_set) begin
      pend_d = 1'b1;
      occ_d  = 1'b0;
      fin_d  = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      creq_q <= 1'b0;
      occ_q  <= 1'b0;
      fin_q  <= 1'b0;
    end else begin
      pend_q <= pend_d;
      creq_q <= creq_d;
      occ_q  <= occ_d;
      fin_q  <= fin_d;
    end
  end

  AST_CREQ_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    (creq_q && !pend_q) |=> !creq_q); // R10
  AST_CANCEL_DEFER: assert property (@(posedge clk) disable iff (!rst_n)
    (is_active && creq_q && !tx_end) |=> pend_q); // R9
  AST_SUCCESS_MARK: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_end && tx_ok && !add_set) |=> (!pend_q && occ_q)); // R6
endmodule

// File: rtl/txq_pending_mgr.sv
module txq_pending_mgr #(
  parameter int NBUF = 32,
  parameter int IDW  = 11,
  localparam int IW  = $clog2(NBUF),
  localparam int CW  = $clog2(NBUF + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [CW-1:0]       cfg_nbuf,
  input  logic                no_retx,
  input  logic                add_we,
  input  logic [NBUF-1:0]     add_data,
  input  logic                cxl_we,
  input  logic [NBUF-1:0]     cxl_data,
  input  logic [NBUF*IDW-1:0] msg_ids,
  output logic                tx_valid,
  input  logic                tx_ready,
  output logic [IW-1:0]       tx_idx,
  input  logic                done_valid,
  input  logic [1:0]          done_status,
  output logic [NBUF-1:0]     pend,
  output logic [NBUF-1:0]     cxl_req,
  output logic [NBUF-1:0]     tx_occ,
  output logic [NBUF-1:0]     cxl_fin
);
  import txq_pkg::*;

  logic            active_q;
  logic [IW-1:0]   act_idx_q;
  logic [NBUF-1:0] in_range, add_set, cxl_set, cand;
  logic            cand_any;
  logic            tx_ok;

  assign tx_ok = (txq_status_e'(done_status) == TXS_OK);

  for (genvar i = 0; i < NBUF; i++) begin : g_slot
    assign in_range[i] = (CW'(i) < cfg_nbuf);
    assign cxl_set[i]  = cxl_we & cxl_data[i];
    assign add_set[i]  = add_we & add_data[i] & in_range[i] & ~cxl_set[i];

    txq_slot u_slot (
      .clk       (clk),
      .rst_n     (rst_n),
      .add_set   (add_set[i]),
      .cxl_set   (cxl_set[i]),
      .is_active (active_q && (act_idx_q == IW'(i))),
      .tx_end    (done_valid && active_q && (act_idx_q == IW'(i))),
      .tx_ok     (tx_ok),
      .no_retx   (no_retx),
      .pend_q    (pend[i]),
      .creq_q    (cxl_req[i]),
      .occ_q     (tx_occ[i]),
      .fin_q     (cxl_fin[i])
    );
  end

  assign cand = pend & ~cxl_req;

  txq_prio_scan #(.NBUF(NBUF), .IDW(IDW)) u_scan (
    .cand (cand),
    .ids  (msg_ids),
    .any  (cand_any),
    .idx  (tx_idx)
  );

  assign tx_valid = cand_any & ~active_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q  <= 1'b0;
      act_idx_q <= '0;
    end else if (active_q) begin
      if (done_valid) active_q <= 1'b0;
    end else if (tx_valid && tx_ready) begin
      active_q  <= 1'b1;
      act_idx_q <= tx_idx;
    end
  end

  AST_OFFER_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> (pend[tx_idx] && !cxl_req[tx_idx])); // R4
  AST_FLIGHT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q && !done_valid) |=> (active_q && $stable(act_idx_q))); // R5
  AST_ADD_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend & ~$past(pend)) & ~$past(in_range)) == '0); // R2
endmodule

// File: tb/txq_pending_mgr_tb.sv
module txq_pending_mgr_tb;
  localparam int NBUF = 32;
  localparam int IDW  = 11;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [5:0]        cfg_nbuf = 6'd8;
  logic              no_retx = 1'b0;
  logic              add_we = 1'b0;
  logic [31:0]       add_data = '0;
  logic              cxl_we = 1'b0;
  logic [31:0]       cxl_data = '0;
  logic [NBUF*IDW-1:0] msg_ids;
  logic              tx_valid;
  logic              tx_ready = 1'b0;
  logic [4:0]        tx_idx;
  logic              done_valid = 1'b0;
  logic [1:0]        done_status = 2'b00;
  logic [31:0]       pend, cxl_req, tx_occ, cxl_fin;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  txq_pending_mgr u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_nbuf(cfg_nbuf), .no_retx(no_retx),
    .add_we(add_we), .add_data(add_data), .cxl_we(cxl_we), .cxl_data(cxl_data),
    .msg_ids(msg_ids), .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_idx(tx_idx),
    .done_valid(done_valid), .done_status(done_status),
    .pend(pend), .cxl_req(cxl_req), .tx_occ(tx_occ), .cxl_fin(cxl_fin)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr_add(input logic [31:0] d);
    add_we = 1'b1; add_data = d;
    @(negedge clk);
    add_we = 1'b0; add_data = '0;
  endtask

  task automatic wr_cxl(input logic [31:0] d);
    cxl_we = 1'b1; cxl_data = d;
    @(negedge clk);
    cxl_we = 1'b0; cxl_data = '0;
  endtask

  task automatic accept();
    tx_ready = 1'b1;
    @(negedge clk);
    tx_ready = 1'b0;
  endtask

  task automatic finish_tx(input logic [1:0] st);
    done_valid = 1'b1; done_status = st;
    @(negedge clk);
    done_valid = 1'b0; done_status = 2'b00;
  endtask

  task automatic t_reset();
    chk("R1 pend", pend, 32'h0);
    chk("R1 cxl_req", cxl_req, 32'h0);
    chk("R1 tx_occ", tx_occ, 32'h0);
    chk("R1 cxl_fin", cxl_fin, 32'h0);
    chk("R1 tx_valid", {31'b0, tx_valid}, 32'h0);
  endtask

  task automatic t_add_range();
    wr_add(32'h0000_0909);
    chk("R2 range-limited set", pend, 32'h0000_0009);
    chk("R4 lowest id of 0,3", {27'b0, tx_idx}, 32'd0);
    wr_add(32'h0);
    chk("R2 zero write no effect", pend, 32'h0000_0009);
    wr_add(32'h0000_0006);
    chk("R2 second set", pend, 32'h0000_000F);
    chk("R5 offer switched before accept / R4 tie to index 1", {27'b0, tx_idx}, 32'd1);
    chk("R4 valid", {31'b0, tx_valid}, 32'd1);
  endtask

  task automatic t_success();
    accept();
    chk("R5 no offer while in flight", {31'b0, tx_valid}, 32'd0);
    @(negedge clk);
    chk("R5 still held", {31'b0, tx_valid}, 32'd0);
    finish_tx(2'b00);
    chk("R6 pend cleared", pend, 32'h0000_000D);
    chk("R6 occurred set", tx_occ, 32'h0000_0002);
    chk("R4 next offer", {27'b0, tx_idx}, 32'd2);
  endtask

  task automatic t_retry();
    accept();
    finish_tx(2'b01);
    chk("R7 arb lost keeps pending", pend, 32'h0000_000D);
    chk("R7 no finish flag", cxl_fin, 32'h0);
    chk("R7 reoffered", {26'b0, tx_valid, tx_idx}, {26'b0, 1'b1, 5'd2});
    accept();
    finish_tx(2'b11);
    chk("R7 error keeps pending", pend, 32'h0000_000D);
    accept();
    finish_tx(2'b00);
    chk("R6 retried frame done", pend, 32'h0000_0009);
    chk("R6 occurred", tx_occ, 32'h0000_0006);
  endtask

  task automatic t_cancel_idle();
    wr_cxl(32'h0000_0008);
    chk("R8 cancel request set", cxl_req, 32'h0000_0008);
    chk("R8 still pending", pend, 32'h0000_0009);
    @(negedge clk);
    chk("R8 pending cleared", pend, 32'h0000_0001);
    chk("R8 finished set", cxl_fin, 32'h0000_0008);
    chk("R10 request one more cycle", cxl_req, 32'h0000_0008);
    @(negedge clk);
    chk("R10 request cleared", cxl_req, 32'h0);
    wr_cxl(32'h0000_0010);
    chk("R10 cancel of idle buffer ignored", cxl_req, 32'h0);
  endtask

  task automatic t_collide();
    add_we = 1'b1; add_data = 32'h20;
    cxl_we = 1'b1; cxl_data = 32'h20;
    @(negedge clk);
    add_we = 1'b0; add_data = '0; cxl_we = 1'b0; cxl_data = '0;
    chk("R3 cancel beats set", pend, 32'h0000_0001);
    wr_add(32'h0000_0008);
    chk("R2 set again", pend, 32'h0000_0009);
    chk("R2 set clears finished", cxl_fin, 32'h0);
  endtask

  task automatic t_cancel_flight();
    chk("R4 offer id 50 over 70", {27'b0, tx_idx}, 32'd0);
    accept();
    wr_cxl(32'h0000_0001);
    chk("R9 request recorded", cxl_req, 32'h0000_0001);
    @(negedge clk);
    @(negedge clk);
    chk("R9 pending held in flight", pend, 32'h0000_0009);
    finish_tx(2'b10);
    chk("R9 failed cancel clears", pend, 32'h0000_0008);
    chk("R9 finished on failure", cxl_fin, 32'h0000_0001);
    chk("R9 no occurred on failure", tx_occ & 32'h1, 32'h0);
    @(negedge clk);
    chk("R10 request cleared", cxl_req, 32'h0);
    accept();
    wr_cxl(32'h0000_0008);
    finish_tx(2'b00);
    chk("R9 ok cancel clears", pend, 32'h0);
    chk("R9 occurred with cancel", tx_occ & 32'h8, 32'h8);
    chk("R9 finished with success", cxl_fin, 32'h0000_0009);
  endtask

  task automatic t_noretx();
    no_retx = 1'b1;
    wr_add(32'h0000_0040);
    chk("R4 sole candidate", {26'b0, tx_valid, tx_idx}, {26'b0, 1'b1, 5'd6});
    accept();
    finish_tx(2'b10);
    chk("R11 pending cleared", pend, 32'h0);
    chk("R11 finished set", cxl_fin & 32'h40, 32'h40);
    chk("R4 nothing offered", {31'b0, tx_valid}, 32'h0);
    no_retx = 1'b0;
  endtask

  initial begin
    for (int i = 0; i < NBUF; i++) msg_ids[i*IDW +: IDW] = IDW'(100 + 10 * i);
    msg_ids[0*IDW +: IDW] = 11'd50;
    msg_ids[1*IDW +: IDW] = 11'd20;
    msg_ids[2*IDW +: IDW] = 11'd20;
    msg_ids[3*IDW +: IDW] = 11'd70;
    msg_ids[6*IDW +: IDW] = 11'd5;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_add_range();
    t_success();
    t_retry();
    t_cancel_idle();
    t_collide();
    t_cancel_flight();
    t_noretx();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule